// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Late Write

This block is a behavioural, synthesizable model of a synchronous flow-through SRAM. Words are 18 bits wide and split into two 9-bit bytes. The depth is a parameter. The block can take a new command on every enabled clock edge. A command is a read, a write, a deselect or a burst continuation, and reads and writes may follow each other in any order with no idle cycles.

Read data flows through. It is driven during the cycle that follows the command edge. Write data trails its command by one enabled edge. The captured write then sits in a pending register until the next enabled edge moves it into the array. A read that targets the pending word gets the pending bytes, merged byte by byte with the stored word.

A clock enable freezes the whole pipeline. A burst engine steps through four-word groups in linear or interleaved order. The data bus is split into an input, an output and a single drive enable. An asynchronous output-enable input gates that drive enable.

Top module: `ft_sram`

## Requirements
- R1: While `rst_n` is low and on the cycles after it is released, `dq_oe` is 0 and no operation is active.
- R2: A read load occurs at an enabled edge with `adv_ld`=0, all chip selects active and `wr_en`=0. During the cycle after that edge, `dq_out` holds the word at `addr` and `dq_oe` equals the inverse of `oe_n`.
- R3: A write load has `wr_en`=1. Its `byte_en` is sampled with the command. Its data is taken from `dq_in` at the next enabled edge. `byte_en[0]` gates bits 8:0 and `byte_en[1]` gates bits 17:9, and a byte whose select is 0 keeps its old contents.
- R4: A read issued on the edge right after a write command to the same address returns the new bytes, merged with the unchanged bytes.
- R5: During the cycle after a write command edge (the write data phase), `dq_oe` is 0 whatever the value of `oe_n`.
- R6: A load needs `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0 at once. Otherwise the load is a deselect: it accesses nothing and `dq_oe` is 0 in the following cycle.
- R7: `dq_oe` is 0 whenever `oe_n` is 1. It follows `oe_n` without waiting for a clock edge.
- R8: An edge with `clk_en`=0 changes nothing. `dq_out` and `dq_oe` hold their values, and a write still waiting for its data samples `dq_in` at the next edge where `clk_en`=1.
- R9: An enabled edge with `adv_ld`=1 repeats the previous operation type at the next burst address. It ignores `wr_en` and the chip selects. A continuation after a deselect stays deselected.
- R10: When `burst_il`=0 at the load, address bits 1:0 of burst step k are (start + k) mod 4. The upper address bits stay fixed.
- R11: When `burst_il`=1 at the load, address bits 1:0 of burst step k are start XOR k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| clk_en | input | 1 | Active-high clock qualifier; 0 ignores the edge |
| addr | input | AW | Word address for a load |
| adv_ld | input | 1 | 1 continues the burst, 0 loads a new command |
| burst_il | input | 1 | Burst order for a load: 0 linear, 1 interleaved |
| wr_en | input | 1 | 1 makes a load a write, 0 a read |
| byte_en | input | 2 | Per-byte write selects, sampled with each command |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 18 | Write data, sampled one enabled edge after the command |
| dq_out | output | 18 | Read data, valid in the cycle after a read command |
| dq_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The bench aims at a read that follows a write to the same word on the very next edge. A design without the pending-register bypass returns stale bytes there, and one that merges carelessly overwrites bytes whose select was off. The bench stalls the clock enable between a write command and its data. A design that samples data on a disabled edge then stores the wrong value, and one that lets the pipeline move during the stall changes `dq_out`. Linear and interleaved bursts start in the middle of a group and continue with the chip selects and `wr_en` toggled. An engine with the wrong order or wrap returns words in the wrong sequence, and one that re-decodes the command inputs breaks off the burst. The bench also toggles `oe_n` between edges and checks the bus after write commands. A design that drives the bus during the write data phase, or that registers `oe_n`, is caught there.

// File: rtl/ft_sram_pkg.sv
`timescale 1ns/100ps
package ft_sram_pkg;
    localparam int BYTE_W  = 9;
    localparam int NBYTES  = 2;
    localparam int DATA_W  = BYTE_W * NBYTES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/ft_sram_burst.sv
`timescale 1ns/100ps
// Burst index generator: linear (wrapping add) or interleaved (xor) order.
module ft_sram_burst #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] start_idx,
    input  logic [BW-1:0] step_idx,
    input  logic          interleave,
    output logic [BW-1:0] word_idx
);
    always_comb begin
        if (interleave) word_idx = start_idx ^ step_idx;
        else            word_idx = start_idx + step_idx;
    end
endmodule

// File: rtl/ft_sram_array.sv
`timescale 1ns/100ps
// Storage array with byte-masked write port and pending-word bypass on read.
module ft_sram_array
    import ft_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              commit,
    input  logic              pend_valid,
    input  logic [AW-1:0]     pend_addr,
    input  logic [DATA_W-1:0] pend_data,
    input  logic [NBYTES-1:0] pend_be,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] stored;
    logic              hit;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (pend_be[b])
                    mem[pend_addr][b*BYTE_W +: BYTE_W] <= pend_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign stored = mem[rd_addr];
    assign hit    = pend_valid && (pend_addr == rd_addr);

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign rd_data[b*BYTE_W +: BYTE_W] = (hit && pend_be[b])
                                           ? pend_data[b*BYTE_W +: BYTE_W]
                                           : stored[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ft_sram_ctrl.sv
`timescale 1ns/100ps
// Command decode, burst state and late-write pending register.
module ft_sram_ctrl
    import ft_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [AW-1:0]     addr,
    input  logic              adv_ld,
    input  logic              burst_il,
    input  logic              wr_en,
    input  logic [NBYTES-1:0] byte_en,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic [DATA_W-1:0] dq_in,
    output op_e               cur_op,
    output logic [AW-1:0]     cur_addr,
    output logic              pend_valid,
    output logic [AW-1:0]     pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic [NBYTES-1:0] pend_be
);
    typedef struct packed {
        op_e                op;
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] cnt;
        logic               il;
        logic [NBYTES-1:0]  be;
        logic               pv;
        logic [AW-1:0]      pa;
        logic [DATA_W-1:0]  pd;
        logic [NBYTES-1:0]  pbe;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic               sel_ok;
    logic [BURST_W-1:0] lo_idx;

    ft_sram_burst #(.BW(BURST_W)) u_burst (
        .start_idx (st_q.base[BURST_W-1:0]),
        .step_idx  (st_q.cnt),
        .interleave(st_q.il),
        .word_idx  (lo_idx)
    );

    assign cur_addr = {st_q.base[AW-1:BURST_W], lo_idx};
    assign sel_ok   = !ce_a_n && ce_b && !ce_c_n;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            // late write: data phase of the write issued at the previous enabled edge
            st_d.pv = (st_q.op == OP_WRITE);
            if (st_q.op == OP_WRITE) begin
                st_d.pa  = cur_addr;
                st_d.pd  = dq_in;
                st_d.pbe = st_q.be;
            end
            st_d.be = byte_en;
            if (adv_ld) begin
                if (st_q.op != OP_IDLE) st_d.cnt = st_q.cnt + 1'b1;
            end else if (sel_ok) begin
                st_d.op   = wr_en ? OP_WRITE : OP_READ;
                st_d.base = addr;
                st_d.cnt  = '0;
                st_d.il   = burst_il;
            end else begin
                st_d.op = OP_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_op     = st_q.op;
    assign pend_valid = st_q.pv;
    assign pend_addr  = st_q.pa;
    assign pend_data  = st_q.pd;
    assign pend_be    = st_q.pbe;
endmodule

// File: rtl/ft_sram.sv
`timescale 1ns/100ps
module ft_sram
    import ft_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [AW-1:0]     addr,
    input  logic              adv_ld,
    input  logic              burst_il,
    input  logic              wr_en,
    input  logic [NBYTES-1:0] byte_en,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    op_e               cur_op;
    logic [AW-1:0]     cur_addr;
    logic              pend_valid;
    logic [AW-1:0]     pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [NBYTES-1:0] pend_be;
    logic [DATA_W-1:0] rd_data;

    ft_sram_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .addr      (addr),
        .adv_ld    (adv_ld),
        .burst_il  (burst_il),
        .wr_en     (wr_en),
        .byte_en   (byte_en),
        .ce_a_n    (ce_a_n),
        .ce_b      (ce_b),
        .ce_c_n    (ce_c_n),
        .dq_in     (dq_in),
        .cur_op    (cur_op),
        .cur_addr  (cur_addr),
        .pend_valid(pend_valid),
        .pend_addr (pend_addr),
        .pend_data (pend_data),
        .pend_be   (pend_be)
    );

    ft_sram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk       (clk),
        .commit    (clk_en && pend_valid),
        .pend_valid(pend_valid),
        .pend_addr (pend_addr),
        .pend_data (pend_data),
        .pend_be   (pend_be),
        .rd_addr   (cur_addr),
        .rd_data   (rd_data)
    );

    assign dq_out = (cur_op == OP_READ) ? rd_data : '0;
    assign dq_oe  = (cur_op == OP_READ) && !oe_n;
endmodule

// File: rtl/ft_sram_chk.sv
`timescale 1ns/100ps
module ft_sram_chk
    import ft_sram_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              adv_ld,
    input logic              wr_en,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);
    logic sel;
    assign sel = !ce_a_n && ce_b && !ce_c_n;

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(dq_out));

    assert_write_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && sel && wr_en) |=> !dq_oe);

    assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !sel) |=> !dq_oe);

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && sel && !wr_en) |=> (dq_oe == !oe_n));
endmodule

bind ft_sram ft_sram_chk u_chk (.*);

// File: tb/ft_sram_tb.sv
`timescale 1ns/100ps
module ft_sram_tb;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;
    localparam int DW    = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1, adv_ld = 1'b0, burst_il = 1'b0, wr_en = 1'b0;
    logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    byte_en = 2'b11;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ft_sram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .adv_ld(adv_ld),
        .burst_il(burst_il), .wr_en(wr_en), .byte_en(byte_en), .ce_a_n(ce_a_n),
        .ce_b(ce_b), .ce_c_n(ce_c_n), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // reference model state (op: 0 idle, 1 read, 2 write)
    logic [DW-1:0] rmem [DEPTH];
    logic [1:0]    rknown [DEPTH];
    int            m_op = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_il = 1'b0;
    logic [1:0]    m_be = '0;
    logic          p_v = 1'b0;
    logic [AW-1:0] p_a = '0;
    logic [DW-1:0] p_d = '0;
    logic [1:0]    p_be = '0;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [17:0] byte_mask(logic [1:0] k);
        return {{9{k[1]}}, {9{k[0]}}};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        logic sel;
        if (!clk_en) return;
        if (p_v) begin
            for (int b = 0; b < 2; b++) begin
                if (p_be[b]) begin
                    rmem[p_a][b*9 +: 9] = p_d[b*9 +: 9];
                    rknown[p_a][b] = 1'b1;
                end
            end
        end
        p_v = (m_op == 2);
        if (m_op == 2) begin
            p_a = m_addr(); p_d = dq_in; p_be = m_be;
        end
        m_be = byte_en;
        sel = !ce_a_n && ce_b && !ce_c_n;
        if (adv_ld) begin
            if (m_op != 0) m_cnt = m_cnt + 2'd1;
        end else if (sel) begin
            m_op = wr_en ? 2 : 1; m_base = addr; m_cnt = '0; m_il = burst_il;
        end else begin
            m_op = 0;
        end
    endtask

    task automatic auto_check();
        logic [AW-1:0] a;
        logic [DW-1:0] e;
        logic [1:0]    k;
        chk("R2 oe", {31'd0, dq_oe}, {31'd0, (m_op == 1) && !oe_n});
        if (m_op == 1) begin
            a = m_addr(); e = rmem[a]; k = rknown[a];
            if (p_v && p_a == a) begin
                for (int b = 0; b < 2; b++)
                    if (p_be[b]) begin e[b*9 +: 9] = p_d[b*9 +: 9]; k[b] = 1'b1; end
            end
            chk("R4 data", {14'd0, dq_out & byte_mask(k)}, {14'd0, e & byte_mask(k)});
        end
    endtask

    task automatic step(bit cen, bit adv, bit sel, bit wr, logic [AW-1:0] a,
                        logic [1:0] be, bit il, logic [DW-1:0] din, bit oe);
        @(negedge clk);
        clk_en = cen; adv_ld = adv; wr_en = wr; addr = a; byte_en = be;
        burst_il = il; dq_in = din; oe_n = oe;
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
        if (!sel) begin
            case ($urandom_range(0, 2))
                0:       ce_a_n = 1'b1;
                1:       ce_b   = 1'b0;
                default: ce_c_n = 1'b1;
            endcase
        end
        @(posedge clk);
        model_edge();
        #1;
        auto_check();
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] va, vb, vc;
        void'($urandom(32'd20231));
        for (int i = 0; i < DEPTH; i++) rknown[i] = 2'b00;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 chk("R1 reset oe", {31'd0, dq_oe}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1 chk("R1 idle after reset", {31'd0, dq_oe}, 32'd0);

        // R3/R4/R5: write then read same word on the next edge
        va = 18'h2AAAA;
        step(1, 0, 1, 1, 10'd8, 2'b11, 0, 18'h0, 0);
        chk("R5 write data phase hi-z", {31'd0, dq_oe}, 32'd0);
        step(1, 0, 1, 0, 10'd8, 2'b11, 0, va, 0);
        chk("R4 bypass full word", {14'd0, dq_out}, {14'd0, va});
        chk("R2 read drives bus", {31'd0, dq_oe}, 32'd1);

        // R3: low byte only, via array
        vb = 18'h00123;
        step(1, 0, 1, 1, 10'd8, 2'b01, 0, 18'h0, 0);
        step(1, 0, 0, 0, 10'd0, 2'b11, 0, vb, 0);
        step(1, 0, 1, 0, 10'd8, 2'b11, 0, 18'h0, 0);
        chk("R3 byte-masked write", {14'd0, dq_out}, {14'd0, (va & 18'h3FE00) | (vb & 18'h001FF)});

        // R4: high byte only, read on next edge through bypass merge
        vc = 18'h3FFFF;
        step(1, 0, 1, 1, 10'd8, 2'b10, 0, 18'h0, 0);
        step(1, 0, 1, 0, 10'd8, 2'b11, 0, vc, 0);
        chk("R4 bypass merge", {14'd0, dq_out}, {14'd0, 18'h3FF23});

        // R7: asynchronous output enable between edges
        oe_n = 1'b1; #0.5;
        chk("R7 oe_n high off", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #0.3;
        chk("R7 oe_n low on", {31'd0, dq_oe}, 32'd1);

        // R8: stalled edge holds the read output
        step(0, 0, 1, 1, 10'd100, 2'b11, 0, 18'h1, 0);
        chk("R8 stall holds data", {14'd0, dq_out}, {14'd0, 18'h3FF23});
        chk("R8 stall holds oe", {31'd0, dq_oe}, 32'd1);
        // R8: write data taken at the next enabled edge, not the stalled one
        step(1, 0, 1, 1, 10'd9, 2'b11, 0, 18'h0, 0);
        step(0, 0, 1, 0, 10'd3, 2'b11, 0, 18'h11111, 0);
        step(1, 0, 1, 0, 10'd9, 2'b11, 0, 18'h0BEEF, 0);
        chk("R8 data after stall", {14'd0, dq_out}, {14'd0, 18'h0BEEF});

        // R6 deselect and R9 continuation after it
        step(1, 0, 0, 0, 10'd9, 2'b11, 0, 18'h0, 0);
        chk("R6 deselect no drive", {31'd0, dq_oe}, 32'd0);
        step(1, 1, 1, 0, 10'd9, 2'b11, 0, 18'h0, 0);
        chk("R9 continue after deselect", {31'd0, dq_oe}, 32'd0);

        // fill 20..23 with 0x100+i
        step(1, 0, 1, 1, 10'd20, 2'b11, 0, 18'h0, 0);
        step(1, 0, 1, 1, 10'd21, 2'b11, 0, 18'h100, 0);
        step(1, 0, 1, 1, 10'd22, 2'b11, 0, 18'h101, 0);
        step(1, 0, 1, 1, 10'd23, 2'b11, 0, 18'h102, 0);
        // R10: linear from 22 -> 22,23,20,21 ; continuations toggle ce and wr_en
        step(1, 0, 1, 0, 10'd22, 2'b11, 0, 18'h103, 0);
        chk("R10 linear k0", {14'd0, dq_out}, 32'h102);
        step(1, 1, 0, 1, 10'd0, 2'b11, 1, 18'h0, 0);
        chk("R10 linear k1", {14'd0, dq_out}, 32'h103);
        step(1, 1, 0, 1, 10'd0, 2'b11, 1, 18'h0, 0);
        chk("R10 linear wrap k2", {14'd0, dq_out}, 32'h100);
        step(1, 1, 1, 1, 10'd0, 2'b11, 1, 18'h0, 0);
        chk("R10 linear k3", {14'd0, dq_out}, 32'h101);
        // R11: interleaved from 21 -> 21,20,23,22
        step(1, 0, 1, 0, 10'd21, 2'b11, 1, 18'h0, 0);
        chk("R11 interleaved k0", {14'd0, dq_out}, 32'h101);
        step(1, 1, 0, 0, 10'd0, 2'b11, 0, 18'h0, 0);
        chk("R11 interleaved k1", {14'd0, dq_out}, 32'h100);
        step(1, 1, 0, 0, 10'd0, 2'b11, 0, 18'h0, 0);
        chk("R11 interleaved k2", {14'd0, dq_out}, 32'h103);
        step(1, 1, 0, 0, 10'd0, 2'b11, 0, 18'h0, 0);
        chk("R11 interleaved k3", {14'd0, dq_out}, 32'h102);

        // R9: burst write from 41 linear with ce off and wr_en low on continues
        step(1, 0, 1, 1, 10'd41, 2'b11, 0, 18'h0, 0);
        step(1, 1, 0, 0, 10'd0, 2'b11, 0, 18'h201, 0);
        chk("R9 write continue hi-z", {31'd0, dq_oe}, 32'd0);
        step(1, 1, 0, 0, 10'd0, 2'b11, 0, 18'h202, 0);
        step(1, 1, 0, 0, 10'd0, 2'b11, 0, 18'h203, 0);
        step(1, 0, 0, 0, 10'd0, 2'b11, 0, 18'h200, 0);
        step(1, 0, 1, 0, 10'd40, 2'b11, 0, 18'h0, 0);
        chk("R9 burst write w40", {14'd0, dq_out}, 32'h200);
        step(1, 1, 0, 1, 10'd0, 2'b11, 0, 18'h0, 0);
        chk("R9 burst write w41", {14'd0, dq_out}, 32'h201);
        step(1, 1, 0, 1, 10'd0, 2'b11, 0, 18'h0, 0);
        chk("R9 burst write w42", {14'd0, dq_out}, 32'h202);
        step(1, 1, 0, 1, 10'd0, 2'b11, 0, 18'h0, 0);
        chk("R9 burst write w43", {14'd0, dq_out}, 32'h203);

        // constrained random traffic checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] ra;
            ra = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, DEPTH-1))
                                             : AW'($urandom_range(0, 15));
            step($urandom_range(0, 9) != 0, $urandom_range(0, 9) < 3,
                 $urandom_range(0, 6) != 0, 1'($urandom_range(0, 1)), ra,
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 18'($urandom), $urandom_range(0, 9) == 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule